// File: doc/BRIEF.md
# Two-Dimensional Hamming Product Encoder

This block turns a 4x4 array of data bits into a 7x7 systematic product codeword. Each of the four data rows gets three Hamming(7,4) check bits. Each of the four data columns gets three Hamming(7,4) check bits, and these form three extra rows. The 3x3 corner in the lower right holds check bits computed over those check bits.

Data enters one bit per cycle in row-major order, qualified by a valid strobe, while the block shows it can take input. Once the sixteenth bit has been taken, the block stops accepting input. It then streams the whole 49-bit codeword out one bit per cycle, without a gap: first the four data rows, each with its check bits after it, and then the three check rows. The cycle after the final bit, it is ready for the next array.

Top module: `hamprod_enc`

## Requirements
- R1: While reset is held and directly after it is released, `in_ready` is 1, `out_valid` is 0 and `out_last` is 0.
- R2: A data bit is taken only on a clock edge where `in_valid` and `in_ready` are both 1. Cycles with `in_valid` low leave the stored array unchanged, and `out_valid` stays 0 until sixteen bits have been taken.
- R3: The cycle after the edge that takes the sixteenth bit, `out_valid` is 1. It stays 1 for exactly 49 consecutive cycles. `out_last` is 1 only on the 49th of these cycles.
- R4: `in_ready` is 0 on every cycle in which `out_valid` is 1. It is 1 again on the cycle after `out_last`.
- R5: Output rows 0 to 3 each carry the four data bits of that row in arrival order (d1 first), followed by p1=d1^d2^d4, p2=d1^d3^d4 and p3=d2^d3^d4. Data bit k of the array arrives as the k-th accepted bit and sits in row k/4, column k%4.
- R6: Output rows 4, 5 and 6 carry, in positions 0 to 3, the check bits p1, p2 and p3 of data column 0 to 3. Each column is encoded with the formulas of R5, using rows 0 to 3 as d1 to d4.
- R7: Positions 4 to 6 of output rows 4 to 6 hold the corner. Row j of the corner is the row encoding of check row j. It equals the column encoding of the row-check columns.
- R8: While the codeword is being emitted, `in_valid` and `in_bit` have no effect: the following array is built only from bits offered after `in_ready` has returned to 1.
- R9: Arrays may follow one another back to back, with or without idle cycles between data bits. Each codeword depends only on its own array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The data bit on `in_bit` is offered |
| in_bit | input | 1 | Serial data bit, row-major order |
| in_ready | output | 1 | The block can take a data bit |
| out_valid | output | 1 | `out_bit` carries a codeword bit |
| out_bit | output | 1 | Serial codeword bit, row-major over 7x7 |
| out_last | output | 1 | Marks the final codeword bit |

## Verification
The bench uses the only geometry the constituent code allows: rows and columns of four data bits, a 7-bit row and column code, and a 49-bit codeword. With this size, blocks whose four rows all share a value cover every one of the sixteen row words. Sixteen single-bit arrays show where each data position reaches the row, column and corner check bits. More than five hundred scrambled arrays, with idle cycles mixed into the input, exercise the column and corner paths in general. In every block, junk is driven onto the input during emission. The corner is predicted in the bench along the column route, and the row route is checked against it.

// File: rtl/prodc_pkg.sv
package prodc_pkg;

    // Constituent code geometry: Hamming(7,4)
    localparam int K         = 4;
    localparam int N         = 7;
    localparam int P         = N - K;
    localparam int DATA_BITS = K * K;
    localparam int CW_BITS   = N * N;
    localparam int DCNT_W    = $clog2(DATA_BITS);
    localparam int POS_W     = $clog2(N);
    localparam int SEL_W     = $clog2(CW_BITS);

    // Position inside the 7x7 output matrix
    typedef struct packed {
        logic [POS_W-1:0] row;
        logic [POS_W-1:0] col;
    } cw_pos_t;

    // Check bits of one 4-bit word, d[0] is d1
    function automatic logic [P-1:0] ham_par(input logic [K-1:0] d);
        logic [P-1:0] p;
        p[0] = d[0] ^ d[1] ^ d[3];
        p[1] = d[0] ^ d[2] ^ d[3];
        p[2] = d[1] ^ d[2] ^ d[3];
        return p;
    endfunction

endpackage

// File: rtl/hamprod_fill.sv
module hamprod_fill
    import prodc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_bit,
    input  logic                 release_i,
    output logic                 in_ready,
    output logic                 full,
    output logic [DATA_BITS-1:0] data
);

    logic [DCNT_W-1:0] cnt;
    logic              accept;
    logic              at_end;

    assign in_ready = !full;
    assign accept   = in_valid && in_ready;
    assign at_end   = (cnt == DCNT_W'(DATA_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            full <= 1'b0;
            data <= '0;
        end else begin
            if (release_i) begin
                full <= 1'b0;
            end
            if (accept) begin
                data[cnt] <= in_bit;
                if (at_end) begin
                    cnt  <= '0;
                    full <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R3: the sixteenth accepted bit closes the array
    assert_fill_done_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && at_end) |=> full);

    // R2, R8: without an accepted bit the stored array holds
    assert_hold_array_R2: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(data));

    // R8: nothing is counted while the array is held
    assert_no_count_full_R8: assert property (@(posedge clk) disable iff (rst)
        full |=> $stable(cnt));

    // R4: a release only happens on a held array
    assert_release_full_R4: assert property (@(posedge clk) disable iff (rst)
        release_i |-> full);

endmodule

// File: rtl/hamprod_matrix.sv
module hamprod_matrix
    import prodc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_BITS-1:0] data,
    output logic [CW_BITS-1:0]   cw
);

    logic [K-1:0] row_d [K];
    logic [P-1:0] row_p [K];
    logic [K-1:0] col_d [K];
    logic [P-1:0] col_p [K];
    logic [K-1:0] chk_d [P];
    logic [P-1:0] chk_p [P];
    logic [K-1:0] rpc_d [P];
    logic [P-1:0] rpc_p [P];

    // Column slices of the array
    always_comb begin
        for (int c = 0; c < K; c++) begin
            for (int r = 0; r < K; r++) begin
                col_d[c][r] = data[r*K + c];
            end
        end
    end

    // Check rows from the column check bits, and row-check columns
    always_comb begin
        for (int j = 0; j < P; j++) begin
            for (int c = 0; c < K; c++) begin
                chk_d[j][c] = col_p[c][j];
            end
            for (int r = 0; r < K; r++) begin
                rpc_d[j][r] = row_p[r][j];
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < K; g++) begin : g_rows
            assign row_d[g] = data[g*K +: K];
            assign row_p[g] = ham_par(row_d[g]);
            assign col_p[g] = ham_par(col_d[g]);
            assign cw[g*N +: N] = {row_p[g], row_d[g]};
        end
        for (g = 0; g < P; g++) begin : g_chk
            assign chk_p[g] = ham_par(chk_d[g]);
            assign rpc_p[g] = ham_par(rpc_d[g]);
            assign cw[(K+g)*N +: N] = {chk_p[g], chk_d[g]};
        end
    endgenerate

    // R7: corner by rows matches corner by columns
    logic [P*P-1:0] corner_rows;
    logic [P*P-1:0] corner_cols;
    always_comb begin
        for (int j = 0; j < P; j++) begin
            for (int q = 0; q < P; q++) begin
                corner_rows[j*P + q] = chk_p[j][q];
                corner_cols[j*P + q] = rpc_p[q][j];
            end
        end
    end

    assert_corner_match_R7: assert property (@(posedge clk) disable iff (rst)
        corner_rows == corner_cols);

endmodule

// File: rtl/hamprod_emit.sv
module hamprod_emit
    import prodc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               full,
    input  logic [CW_BITS-1:0] cw,
    output logic               out_valid,
    output logic               out_bit,
    output logic               out_last,
    output logic               release_o
);

    cw_pos_t          pos;
    logic [SEL_W-1:0] sel;
    logic             row_end;
    logic             mat_end;

    assign row_end = (pos.col == POS_W'(N - 1));
    assign mat_end = row_end && (pos.row == POS_W'(N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (full) begin
            if (row_end) begin
                pos.col <= '0;
                pos.row <= mat_end ? '0 : pos.row + 1'b1;
            end else begin
                pos.col <= pos.col + 1'b1;
            end
        end
    end

    assign sel       = SEL_W'(pos.row) * SEL_W'(N) + SEL_W'(pos.col);
    assign out_valid = full;
    assign out_bit   = full && cw[sel];
    assign out_last  = full && mat_end;
    assign release_o = out_last;

    // R3: emission runs without a gap until the last bit
    assert_no_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    // R3: the last bit ends emission
    assert_end_R3: assert property (@(posedge clk) disable iff (rst)
        out_last |=> !out_valid);

    // R3: position restarts at the matrix origin between blocks
    assert_pos_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !full |-> (pos == '0));

    // R5: the column never leaves the matrix
    assert_col_range_R5: assert property (@(posedge clk) disable iff (rst)
        pos.col < POS_W'(N));

endmodule

// File: rtl/hamprod_enc.sv
module hamprod_enc
    import prodc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit,
    output logic out_last
);

    logic                 full;
    logic                 release_s;
    logic [DATA_BITS-1:0] data;
    logic [CW_BITS-1:0]   cw;

    hamprod_fill u_fill (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .release_i (release_s),
        .in_ready  (in_ready),
        .full      (full),
        .data      (data)
    );

    hamprod_matrix u_matrix (
        .clk  (clk),
        .rst  (rst),
        .data (data),
        .cw   (cw)
    );

    hamprod_emit u_emit (
        .clk       (clk),
        .rst       (rst),
        .full      (full),
        .cw        (cw),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_last  (out_last),
        .release_o (release_s)
    );

    // R4: no input is taken during emission
    assert_ready_low_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R4: input opens again right after the last bit
    assert_ready_back_R4: assert property (@(posedge clk) disable iff (rst)
        out_last |=> in_ready);

    // R1: outputs are quiet right after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_last && in_ready));

endmodule

// File: tb/hamprod_enc_tb.sv
module hamprod_enc_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_ready, out_valid, out_bit, out_last;

    int n_checks = 0;
    int n_fail   = 0;
    int n_vec    = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hamprod_enc u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_last  (out_last)
    );

    function automatic logic [2:0] enc3(input logic [3:0] d);
        enc3 = {d[1] ^ d[2] ^ d[3], d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_block(input logic [15:0] d, input int seed);
        logic [48:0] e;
        logic [2:0]  rp [4];
        string       tag;
        e = '0;
        for (int r = 0; r < 4; r++) begin
            e[r*7 +: 4]     = d[r*4 +: 4];
            rp[r]           = enc3(d[r*4 +: 4]);
            e[r*7 + 4 +: 3] = rp[r];
        end
        for (int c = 0; c < 4; c++) begin
            logic [2:0] cp;
            cp = enc3({d[12+c], d[8+c], d[4+c], d[c]});
            for (int j = 0; j < 3; j++) e[(4+j)*7 + c] = cp[j];
        end
        // R7: corner along the column route
        for (int q = 0; q < 3; q++) begin
            logic [2:0] v;
            v = enc3({rp[3][q], rp[2][q], rp[1][q], rp[0][q]});
            for (int j = 0; j < 3; j++) e[(4+j)*7 + 4 + q] = v[j];
        end
        // R7: row route agrees with the column route
        for (int j = 0; j < 3; j++)
            check("R7 corner routes", 32'(enc3(e[(4+j)*7 +: 4])), 32'(e[(4+j)*7 + 4 +: 3]));

        // send, with idle cycles carrying junk (R2, R9)
        for (int i = 0; i < 16; i++) begin
            if (((seed + i) % 5) == 0) begin
                in_valid = 1'b0;
                in_bit   = ~d[i];
                @(negedge clk);
                check("R2 idle ready", 32'(in_ready), 32'd1);
            end
            check("R2 no early out", 32'(out_valid), 32'd0);
            in_valid = 1'b1;
            in_bit   = d[i];
            @(negedge clk);
        end
        // emission, junk on the input (R8)
        for (int k = 0; k < 49; k++) begin
            tag = $sformatf("R5/R6/R7 bit %0d", k);
            if (k < 28) tag = $sformatf("R5 bit %0d", k);
            else if ((k % 7) < 4) tag = $sformatf("R6 bit %0d", k);
            else tag = $sformatf("R7 bit %0d", k);
            check("R3 valid", 32'(out_valid), 32'd1);
            check("R4 ready low", 32'(in_ready), 32'd0);
            check("R3 last", 32'(out_last), 32'(k == 48));
            check(tag, 32'(out_bit), 32'(e[k]));
            in_valid = (k != 48);
            in_bit   = k[0] ^ d[k % 16];
            @(negedge clk);
        end
        in_valid = 1'b0;
        check("R3 end valid", 32'(out_valid), 32'd0);
        check("R4 ready back", 32'(in_ready), 32'd1);
        n_vec++;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !finished) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog R3 actual=%0d expected<%0d", cycles, WATCHDOG);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 32'd0);
        check("R1 reset last", 32'(out_last), 32'd0);
        check("R1 reset ready", 32'(in_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post valid", 32'(out_valid), 32'd0);
        check("R1 post ready", 32'(in_ready), 32'd1);
        // R5: every row word, all rows equal
        for (int v = 0; v < 16; v++)
            run_block({4{4'(v)}}, v);
        // R6/R7: single-bit arrays
        for (int b = 0; b < 16; b++)
            run_block(16'(1) << b, b + 3);
        run_block(16'h0000, 1);
        run_block(16'hFFFF, 2);
        // R9: scrambled arrays back to back
        for (int k = 0; k < 520; k++) begin
            logic [15:0] s;
            s = 16'((k * 32'hA5B7 + 32'h3C1) ^ (k << 7) ^ (k >> 2));
            run_block(s, k);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule